// File: doc/BRIEF.md
# Low-Frequency Down-Counting Tick Timer

This block is a down-counter clocked from a slow 32768 Hz clock and programmed through a simple register strobe interface that runs on a faster bus clock. Software writes a reload value and then sets a start control bit. The rising edge of that bit passes through a synchronizer into the slow domain and copies the reload value into the counter. The counter then decrements by one on every slow-clock tick.

When the count steps down to zero, an expiry event goes back to the bus domain. It sets a sticky status flag, and that flag drives the interrupt line while the interrupt enable is set. If the reload value is nonzero when the count hits zero, the counter refills from it and keeps running. If the reload value is zero, the counter stops. A debug-halt control can freeze the count while an external halt input is asserted. The count and a running flag are copied into a bus-domain snapshot register for readback.

Top module: `lowfreq_downtimer`

## Requirements
- R1: After reset the control, reload, count and status registers all read zero and `irq` is low.
- R2: A 0-to-1 change of the start bit (control bit 2), with enable (control bit 0) set, loads the count from the reload register (address 1). The count then drops by exactly one per slow-clock tick.
- R3: After the start bit is set, and before the load has happened in the slow domain, the count register (address 2) reads zero while the start bit reads one. The running flag (control bit 4, read-only) reads one only once the counter has been loaded.
- R4: Writing the reload register while the counter runs does not change the current count. The new value is used at the next expiry.
- R5: The step from one to zero sets status bit 0 (address 3). `irq` is high exactly when that bit is set and interrupt enable (control bit 1) is set.
- R6: At expiry, a nonzero reload value refills the count and counting continues. A zero reload value leaves the count at zero with the running flag cleared.
- R7: Writing a one to status bit 0 clears it. Writing a zero leaves it set.
- R8: Clearing the start bit stops the counter, clears the running flag and returns the count to zero.
- R9: With debug-halt enable (control bit 3) set, asserting `halt_in` freezes the count. `halt_in` has no effect while bit 3 is clear.
- R10: While enable is clear the count is frozen. Setting enable again resumes counting from the held value.
- R11: Writes to the count register have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register interface clock |
| slow_clk | input | 1 | 32768 Hz counting clock |
| rst_n | input | 1 | Asynchronous active-low reset, released per domain |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 control, 1 reload, 2 count, 3 status |
| wr_data | input | DW | Write data |
| rd_data | output | DW | Read data for the selected register |
| halt_in | input | 1 | External debug halt request |
| irq | output | 1 | Interrupt, level, follows status and interrupt enable |

## Verification
A corrupted count register shows at the ports within one slow tick, because the snapshot readback is compared against the exact value expected for every tick after the load. A wrong start-edge detector or synchronizer depth moves the load by a tick. That is seen during the pending window, when the count must still read zero, and again on the first tick after the load. A bad expiry path either misses the status flag at the tick where the count refills or sets it early. A reload that is applied too soon shows up one tick after the mid-run write.

// File: rtl/lfd_pkg.sv
package lfd_pkg;
  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_RELOAD = 2'd1,
    REG_COUNT  = 2'd2,
    REG_STAT   = 2'd3
  } lfd_reg_e;

  localparam int CTL_EN     = 0;
  localparam int CTL_IEN    = 1;
  localparam int CTL_START  = 2;
  localparam int CTL_HALTEN = 3;
  localparam int CTL_RUN    = 4;
  localparam int CTL_W      = 4;
endpackage

// File: rtl/lfd_rstsync.sv
module lfd_rstsync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= 2'b00;
    else         sh_q <= {sh_q[0], 1'b1};
  end

  assign srst_n = sh_q[1];
endmodule

// File: rtl/lfd_sync.sv
module lfd_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q[g] <= '0;
        else        st_q[g] <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q[g] <= '0;
        else        st_q[g] <= st_q[g-1];
      end
    end
  end

  assign q = st_q[STAGES-1];
endmodule

// File: rtl/lfd_core.sv
module lfd_core #(
  parameter int CW = 28
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_en,
  input  logic          ctl_start,
  input  logic          ctl_halten,
  input  logic          halt_in,
  input  logic [CW-1:0] reload,
  output logic [CW-1:0] cnt,
  output logic          running,
  output logic          exp_tgl,
  output logic          upd_tgl
);
  logic [3:0] s;
  logic en_s, st_s, he_s, h_s;
  logic st_p_q, rise, frozen, step;
  logic [CW-1:0] cnt_q, cnt_d;
  logic run_q, run_d, exp_q, exp_d, upd_q;

  lfd_sync #(.W(4), .STAGES(2)) u_in_sync (
    .clk(clk), .rst_n(rst_n),
    .d({halt_in, ctl_halten, ctl_start, ctl_en}), .q(s)
  );

  assign en_s   = s[0];
  assign st_s   = s[1];
  assign he_s   = s[2];
  assign h_s    = s[3];
  assign rise   = st_s & ~st_p_q;
  assign frozen = he_s & h_s;
  assign step   = run_q & en_s & ~frozen;

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    exp_d = exp_q;
    if (!st_s) begin
      run_d = 1'b0;
      cnt_d = '0;
    end else if (rise && en_s) begin
      cnt_d = reload;
      run_d = (reload != '0);
    end else if (step) begin
      if (cnt_q <= CW'(1)) begin
        exp_d = ~exp_q;
        if (reload != '0) begin
          cnt_d = reload;
        end else begin
          cnt_d = '0;
          run_d = 1'b0;
        end
      end else begin
        cnt_d = cnt_q - CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      exp_q  <= 1'b0;
      upd_q  <= 1'b0;
      st_p_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      run_q  <= run_d;
      exp_q  <= exp_d;
      upd_q  <= ~upd_q;
      st_p_q <= st_s;
    end
  end

  assign cnt     = cnt_q;
  assign running = run_q;
  assign exp_tgl = exp_q;
  assign upd_tgl = upd_q;

  // R2: a synchronized start edge with enable copies the reload value
  assert_load_on_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && en_s) |=> (cnt_q == $past(reload)));

  // R2: one decrement per tick while counting above one
  assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_s && !rise && step && cnt_q > CW'(1)) |=> (cnt_q == $past(cnt_q) - CW'(1)));

  // R9: frozen counter holds its value
  assert_halt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_s && !rise && frozen) |=> $stable(cnt_q));

  // R6: reaching zero always emits an expiry event
  assert_expiry_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_s && !rise && step && cnt_q == CW'(1)) |=> (exp_q != $past(exp_q)));
endmodule

// File: rtl/lfd_regs.sv
module lfd_regs
  import lfd_pkg::*;
#(
  parameter int CW = 28,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          ctl_en,
  output logic          ctl_start,
  output logic          ctl_halten,
  output logic [CW-1:0] reload,
  input  logic [CW-1:0] cnt_slow,
  input  logic          run_slow,
  input  logic          exp_tgl,
  input  logic          upd_tgl,
  output logic          irq
);
  logic [1:0] tg_s;
  logic [CTL_W-1:0] ctl_q, ctl_d;
  logic [CW-1:0] pre_q, pre_d, snap_q, snap_d;
  logic srun_q, srun_d, stat_q, stat_d;
  logic exp_p_q, upd_p_q;
  logic cap, exp_evt, wr_ctl, wr_pre, wr_stat;
  logic unused_wr_hi;

  lfd_sync #(.W(2), .STAGES(2)) u_tgl_sync (
    .clk(clk), .rst_n(rst_n), .d({exp_tgl, upd_tgl}), .q(tg_s)
  );

  assign cap          = tg_s[0] ^ upd_p_q;
  assign exp_evt      = tg_s[1] ^ exp_p_q;
  assign wr_ctl       = wr_en && (addr == 2'(REG_CTRL));
  assign wr_pre       = wr_en && (addr == 2'(REG_RELOAD));
  assign wr_stat      = wr_en && (addr == 2'(REG_STAT));
  assign unused_wr_hi = ^wr_data[DW-1:CW];

  always_comb begin
    ctl_d  = ctl_q;
    pre_d  = pre_q;
    stat_d = stat_q;
    snap_d = snap_q;
    srun_d = srun_q;
    if (wr_ctl) ctl_d = wr_data[CTL_W-1:0];
    if (wr_pre) pre_d = wr_data[CW-1:0];
    if (wr_stat && wr_data[0]) stat_d = 1'b0;
    if (exp_evt) stat_d = 1'b1;
    if (cap) begin
      snap_d = cnt_slow;
      srun_d = run_slow;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      pre_q   <= '0;
      stat_q  <= 1'b0;
      snap_q  <= '0;
      srun_q  <= 1'b0;
      exp_p_q <= 1'b0;
      upd_p_q <= 1'b0;
    end else begin
      ctl_q   <= ctl_d;
      pre_q   <= pre_d;
      stat_q  <= stat_d;
      snap_q  <= snap_d;
      srun_q  <= srun_d;
      exp_p_q <= tg_s[1];
      upd_p_q <= tg_s[0];
    end
  end

  always_comb begin
    rd_data = '0;
    case (lfd_reg_e'(addr))
      REG_CTRL: begin
        rd_data[CTL_W-1:0] = ctl_q;
        rd_data[CTL_RUN]   = srun_q;
      end
      REG_RELOAD: rd_data[CW-1:0] = pre_q;
      REG_COUNT:  rd_data[CW-1:0] = snap_q;
      default:    rd_data[0]      = stat_q;
    endcase
  end

  assign ctl_en     = ctl_q[CTL_EN];
  assign ctl_start  = ctl_q[CTL_START];
  assign ctl_halten = ctl_q[CTL_HALTEN];
  assign reload     = pre_q;
  assign irq        = stat_q & ctl_q[CTL_IEN];

  // R7: a one written to status clears it unless an expiry lands together
  assert_w1c_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && wr_data[0] && !exp_evt) |=> !stat_q);

  // R5: an expiry event always leaves the flag set
  assert_expiry_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    exp_evt |=> stat_q);

  // R11: writing the count address never alters the snapshot
  assert_count_ro_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'(REG_COUNT) && !cap) |=> $stable(snap_q));
endmodule

// File: rtl/lowfreq_downtimer.sv
module lowfreq_downtimer #(
  parameter int CW = 28,
  parameter int DW = 32
) (
  input  logic          bus_clk,
  input  logic          slow_clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic          halt_in,
  output logic          irq
);
  logic brst_n, srst_n;
  logic ctl_en, ctl_start, ctl_halten;
  logic [CW-1:0] reload, cnt;
  logic running, exp_tgl, upd_tgl;

  lfd_rstsync u_brst (.clk(bus_clk),  .arst_n(rst_n), .srst_n(brst_n));
  lfd_rstsync u_srst (.clk(slow_clk), .arst_n(rst_n), .srst_n(srst_n));

  lfd_regs #(.CW(CW), .DW(DW)) u_regs (
    .clk(bus_clk), .rst_n(brst_n), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .ctl_en(ctl_en),
    .ctl_start(ctl_start), .ctl_halten(ctl_halten), .reload(reload),
    .cnt_slow(cnt), .run_slow(running), .exp_tgl(exp_tgl),
    .upd_tgl(upd_tgl), .irq(irq)
  );

  lfd_core #(.CW(CW)) u_core (
    .clk(slow_clk), .rst_n(srst_n), .ctl_en(ctl_en),
    .ctl_start(ctl_start), .ctl_halten(ctl_halten), .halt_in(halt_in),
    .reload(reload), .cnt(cnt), .running(running),
    .exp_tgl(exp_tgl), .upd_tgl(upd_tgl)
  );
endmodule

// File: tb/lowfreq_downtimer_test.sv
module lowfreq_downtimer_test;
  logic bus_clk = 1'b0;
  logic slow_clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [31:0] wr_data = '0;
  logic halt_in = 1'b0;
  logic [31:0] rd_data;
  logic irq;
  int checks = 0;
  int errors = 0;

  lowfreq_downtimer uut (
    .bus_clk(bus_clk), .slow_clk(slow_clk), .rst_n(rst_n), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
    .halt_in(halt_in), .irq(irq)
  );

  always #5 bus_clk = ~bus_clk;
  initial begin
    #3;
    forever #80 slow_clk = ~slow_clk;
  end

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic logic [31:0] exp_cnt(input int p, input int k);
    return 32'(p - (k % p));
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge slow_clk);
      repeat (8) @(posedge bus_clk);
      #1;
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge bus_clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge bus_clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rd_data;
  endtask

  // stop, clear status, load p, set start with irq enable ien; returns at load tick
  task automatic start_run(input int p, input logic ien);
    logic [31:0] v;
    wr(2'd0, 32'h3);
    tick(4);
    wr(2'd3, 32'h1);
    wr(2'd1, 32'(p));
    tick(1);
    wr(2'd0, ien ? 32'h7 : 32'h5);
    for (int i = 0; i < 2; i++) begin
      tick(1);
      rd(2'd2, v); chk("R3 pending count zero", v, 32'h0);
      rd(2'd0, v); chk("R3 start set, running clear", v & 32'h14, 32'h04);
    end
    tick(1);
    rd(2'd2, v); chk("R2 load from reload", v, 32'(p));
    rd(2'd0, v); chk("R3 running after load", v[4], 32'h1);
  endtask

  initial begin
    logic [31:0] v, c0, c1;
    void'($urandom(32'd20240611));
    #400;
    rst_n = 1'b1;
    tick(3);

    rd(2'd0, v); chk("R1 ctrl reset", v, 0);
    rd(2'd1, v); chk("R1 reload reset", v, 0);
    rd(2'd2, v); chk("R1 count reset", v, 0);
    rd(2'd3, v); chk("R1 status reset", v, 0);
    chk("R1 irq reset", irq, 0);

    // random runs: R2 stepping, R6 reload, R5 status, R11 read-only count
    for (int t = 0; t < 10; t++) begin
      int p;
      p = 2 + int'($urandom_range(0, 18));
      start_run(p, 1'b1);
      for (int k = 1; k <= p + 2; k++) begin
        if (k == 1) wr(2'd2, 32'hABC);
        tick(1);
        rd(2'd2, v); chk("R2 R6 R11 count per tick", v, exp_cnt(p, k));
        rd(2'd3, v); chk("R5 status at expiry", v, (k >= p) ? 32'h1 : 32'h0);
        chk("R5 irq with enable", irq, (k >= p) ? 1'b1 : 1'b0);
      end
    end

    // R4: reload rewrite mid-run applies at next expiry
    start_run(8, 1'b1);
    tick(2);
    wr(2'd1, 32'd3);
    tick(1);
    rd(2'd2, v); chk("R4 count unaffected by reload write", v, 32'd5);
    tick(5);
    rd(2'd2, v); chk("R4 new reload at expiry", v, 32'd3);
    tick(3);
    rd(2'd2, v); chk("R4 R6 period of new reload", v, 32'd3);

    // R6: zero reload stops at expiry
    start_run(5, 1'b1);
    tick(1);
    wr(2'd1, 32'd0);
    tick(4);
    rd(2'd2, v); chk("R6 one-shot count zero", v, 0);
    rd(2'd0, v); chk("R6 one-shot not running", v[4], 0);
    rd(2'd3, v); chk("R6 one-shot status", v, 1);
    tick(3);
    rd(2'd2, v); chk("R6 one-shot stays zero", v, 0);

    // R5/R7: irq gating and write-one-to-clear
    start_run(3, 1'b0);
    tick(3);
    rd(2'd3, v); chk("R5 status without irq enable", v, 1);
    chk("R5 irq masked", irq, 0);
    wr(2'd0, 32'h3);
    tick(4);
    chk("R5 irq when enabled", irq, 1);
    wr(2'd3, 32'h0);
    tick(1);
    rd(2'd3, v); chk("R7 zero write keeps status", v, 1);
    wr(2'd3, 32'h1);
    tick(1);
    rd(2'd3, v); chk("R7 one write clears status", v, 0);
    chk("R7 irq drops after clear", irq, 0);

    // R9/R10/R8 on a long run
    start_run(200, 1'b1);
    tick(4);
    @(negedge bus_clk); halt_in = 1'b1;
    tick(2);
    rd(2'd2, c0); tick(3); rd(2'd2, c1);
    chk("R9 halt input ignored without enable", c1, c0 - 3);
    wr(2'd0, 32'hF);
    tick(4);
    rd(2'd2, c0); tick(4); rd(2'd2, c1);
    chk("R9 halted count frozen", c1, c0);
    @(negedge bus_clk); halt_in = 1'b0;
    tick(4);
    rd(2'd2, c0); tick(3); rd(2'd2, c1);
    chk("R9 counting resumes after halt", c1, c0 - 3);
    wr(2'd0, 32'h6);
    tick(4);
    rd(2'd2, c0); tick(4); rd(2'd2, c1);
    chk("R10 disabled count frozen", c1, c0);
    wr(2'd0, 32'h7);
    tick(4);
    rd(2'd2, c0); tick(2); rd(2'd2, c1);
    chk("R10 resumes after enable", c1, c0 - 2);
    wr(2'd0, 32'h3);
    tick(4);
    rd(2'd2, v); chk("R8 stop clears count", v, 0);
    rd(2'd0, v); chk("R8 stop clears running", v[4], 0);
    tick(3);
    rd(2'd2, v); chk("R8 stays stopped", v, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule